// File: doc/BRIEF.md
# Eight-Register Block Load Sequencer

This block carries out a single load instruction that fills a whole aligned group of eight 64-bit architectural registers from one memory burst. The requester supplies a base byte address and a group index. The block issues one burst request on an internal 256-bit bus and accepts the response as two beats. It cuts each beat into four 64-bit words and drives them onto a single register-file write port, one word per cycle in ascending register order. A one-cycle completion pulse follows the last write.

The main use is explicit preloading for double-buffered loops. Software starts a load of eight values into one group while it computes on another group. A base address that does not sit on a 64-byte boundary is rejected with an error pulse. In that case no memory request and no register write take place. Register zero is never written, so a load into the lowest group updates only registers 1 to 7.

Top module: `blk_ld_seq`

## Requirements
- R1: While reset is held, req_ready_o is 1 and busy_o, done_o, err_o, rf_we_o, mem_req_valid_o and mem_rsp_ready_o are all 0.
- R2: An accepted request with an aligned base produces exactly one memory request, and its mem_req_addr_o equals the base.
- R3: A base whose low 6 bits are not all zero sets err_o for exactly the one cycle after acceptance. That request produces no memory request, no register write and no busy cycle.
- R4: For response beat b (0 or 1), the word in bits [64k+63:64k] is written to register group*8 + b*4 + k. Writes come in ascending register order, one per cycle, starting in the cycle after the beat is accepted.
- R5: For group 0, the write to register 0 is discarded, so rf_we_o stays 0 in that slot. Register 1 is still written in the following cycle, and only seven writes occur.
- R6: mem_rsp_ready_o is 1 only while a beat is awaited. The response may stall for any number of cycles without a word being lost or written early.
- R7: busy_o rises in the cycle after acceptance and stays 1 through the eighth write slot. With no bus stalls this is exactly 11 cycles. done_o is 1 for exactly one cycle, the one right after the last write slot, and busy_o is 0 in that cycle.
- R8: While busy_o is 1, req_ready_o is 0 and a presented request is ignored: it causes no second memory request and no extra write.
- R9: While mem_req_ready_i is 0, mem_req_valid_o stays 1 and mem_req_addr_o stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Sequencer idle, able to take a request |
| req_base_i | input | 32 | Base byte address of the burst |
| req_group_i | input | 2 | Index of the destination group of eight registers |
| mem_req_valid_o | output | 1 | Burst request valid |
| mem_req_ready_i | input | 1 | Burst request taken by memory |
| mem_req_addr_o | output | 32 | Burst base address |
| mem_rsp_valid_i | input | 1 | Response beat valid |
| mem_rsp_ready_o | output | 1 | Sequencer can take a beat |
| mem_rsp_data_i | input | 256 | Response beat data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 64 | Register-file write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle misalignment error pulse |

## Verification
The loads use distinct groups and bases, and every word carries its base, beat and lane in its value. A wrong lane slice, a swapped beat or a wrong register offset therefore shows up as a data or index mismatch. A stall-free load pins down the exact busy length and the position of the done pulse. A load with long request and response stalls tells apart correct waiting from words written before their beat arrives. Group 0 separates discarding register zero from dropping or shifting the remaining slots. A misaligned base and a request held during a busy load show whether rejected or ignored requests leak into the bus or the register file.

// File: rtl/blk_ld_pkg.sv
`timescale 1ns/1ps
package blk_ld_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_WR   = 2'd3
  } ld_state_e;

  function automatic int clog2_min1(int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/blk_ld_align.sv
`timescale 1ns/1ps
module blk_ld_align #(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              misaligned_o
);

  assign misaligned_o = |addr_i[ALIGN_W-1:0];

endmodule

// File: rtl/blk_ld_beat_buf.sv
`timescale 1ns/1ps
module blk_ld_beat_buf #(
  parameter int BUS_W  = 256,
  parameter int WORD_W = 64,
  localparam int WPB    = BUS_W / WORD_W,
  localparam int WSEL_W = blk_ld_pkg::clog2_min1(WPB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BUS_W-1:0]  data_i,
  input  logic [WSEL_W-1:0] sel_i,
  output logic [WORD_W-1:0] word_o
);

  logic [BUS_W-1:0]  buf_q;
  logic [WORD_W-1:0] lane [WPB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     buf_q <= '0;
    else if (load_i) buf_q <= data_i;
  end

  for (genvar g = 0; g < WPB; g++) begin : g_lane
    assign lane[g] = buf_q[g*WORD_W +: WORD_W];
  end

  assign word_o = lane[sel_i];

endmodule

// File: rtl/blk_ld_ctrl.sv
`timescale 1ns/1ps
module blk_ld_ctrl
  import blk_ld_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GROUP_REGS = 8,
  parameter int WPB        = 4,
  parameter int REG_AW     = 5,
  localparam int BEATS     = GROUP_REGS / WPB,
  localparam int BEAT_W    = clog2_min1(BEATS),
  localparam int WSEL_W    = clog2_min1(WPB),
  localparam int GRP_W     = REG_AW - $clog2(GROUP_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [GRP_W-1:0]  req_group_i,
  input  logic              misaligned_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  output logic              beat_load_o,
  output logic [WSEL_W-1:0] wsel_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  ld_state_e         state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic              wr_slot;
  logic [REG_AW-1:0] waddr;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    wsel_d  = wsel_q;
    grp_d   = grp_q;
    base_d  = base_q;
    err_d   = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (misaligned_i) begin
            err_d = 1'b1;
          end else begin
            grp_d   = req_group_i;
            base_d  = req_base_i;
            beat_d  = '0;
            state_d = ST_REQ;
          end
        end
      end
      ST_REQ: if (mem_req_ready_i) state_d = ST_RSP;
      ST_RSP: begin
        if (mem_rsp_valid_i) begin
          wsel_d  = '0;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        wsel_d = wsel_q + WSEL_W'(1);
        if (wsel_q == WSEL_W'(WPB-1)) begin
          if (beat_q == BEAT_W'(BEATS-1)) begin
            beat_d  = '0;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            beat_d  = beat_q + BEAT_W'(1);
            state_d = ST_RSP;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      wsel_q  <= '0;
      grp_q   <= '0;
      base_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      wsel_q  <= wsel_d;
      grp_q   <= grp_d;
      base_q  <= base_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign wr_slot = (state_q == ST_WR);
  assign waddr   = REG_AW'(int'(grp_q) * GROUP_REGS + int'(beat_q) * WPB + int'(wsel_q));

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = base_q;
  assign mem_rsp_ready_o = (state_q == ST_RSP);
  assign beat_load_o     = mem_rsp_ready_o && mem_rsp_valid_i;
  assign wsel_o          = wsel_q;
  // register zero is hard-wired: its slot is spent but not written
  assign rf_we_o         = wr_slot && (waddr != '0);
  assign rf_waddr_o      = waddr;
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = done_q;
  assign err_o           = err_q;

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o))
    else $error("request dropped or changed while stalled");

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  p_done_after_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_slot) && !busy_o)
    else $error("done not right after last write slot");

  p_err_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !rf_we_o && !mem_req_valid_o)
    else $error("error pulse with activity");

  p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_valid_i |=> $stable(base_q) && $stable(grp_q))
    else $error("request taken while busy");

  p_rsp_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_ready_o && !mem_rsp_valid_i |=> mem_rsp_ready_o && !wr_slot && $stable(beat_q))
    else $error("progress without a beat");

  p_wr_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_slot && (wsel_q != '0) |-> $past(wr_slot) && (waddr == $past(waddr) + REG_AW'(1)))
    else $error("write slots out of order");

endmodule

// File: rtl/blk_ld_seq.sv
`timescale 1ns/1ps
module blk_ld_seq #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 64,
  parameter int BUS_W      = 256,
  parameter int GROUP_REGS = 8,
  parameter int REG_AW     = 5,
  localparam int WPB       = BUS_W / WORD_W,
  localparam int WSEL_W    = blk_ld_pkg::clog2_min1(WPB),
  localparam int ALIGN_W   = $clog2(GROUP_REGS * WORD_W / 8),
  localparam int GRP_W     = REG_AW - $clog2(GROUP_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [GRP_W-1:0]  req_group_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [BUS_W-1:0]  mem_rsp_data_i,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [WORD_W-1:0] rf_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  logic              misaligned;
  logic              beat_load;
  logic [WSEL_W-1:0] wsel;

  blk_ld_align #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_align (
    .addr_i       (req_base_i),
    .misaligned_o (misaligned)
  );

  blk_ld_ctrl #(
    .ADDR_W(ADDR_W), .GROUP_REGS(GROUP_REGS), .WPB(WPB), .REG_AW(REG_AW)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_base_i      (req_base_i),
    .req_group_i     (req_group_i),
    .misaligned_i    (misaligned),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_ready_o (mem_rsp_ready_o),
    .beat_load_o     (beat_load),
    .wsel_o          (wsel),
    .rf_we_o         (rf_we_o),
    .rf_waddr_o      (rf_waddr_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .err_o           (err_o)
  );

  blk_ld_beat_buf #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (beat_load),
    .data_i (mem_rsp_data_i),
    .sel_i  (wsel),
    .word_o (rf_wdata_o)
  );

endmodule

// File: tb/blk_ld_seq_tb.sv
`timescale 1ns/1ps
module blk_ld_seq_tb;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [31:0]  req_base_i = '0;
  logic [1:0]   req_group_i = '0;
  logic         mem_req_valid_o;
  logic         mem_req_ready_i = 1'b0;
  logic [31:0]  mem_req_addr_o;
  logic         mem_rsp_valid_i = 1'b0;
  logic         mem_rsp_ready_o;
  logic [255:0] mem_rsp_data_i = '0;
  logic         rf_we_o;
  logic [4:0]   rf_waddr_o;
  logic [63:0]  rf_wdata_o;
  logic         busy_o, done_o, err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  blk_ld_seq u_dut (.*);

  // memory model and monitor state
  int req_wait = 0, rsp_gap = 0;
  int waitc = 0, gapc = 0, pend = 0, beat_i = 0;
  int req_cnt = 0;
  logic [31:0] got_addr = '0;
  logic prev_req_vld = 1'b0, prev_rsp_rdy = 1'b0;
  logic [31:0] prev_addr = '0;
  int cyc = 0, wr_n = 0, last_wr_cyc = 0, done_cyc = 0;
  int busy_cyc = 0, done_cnt = 0, err_cnt = 0;
  logic [4:0]  wr_a [16];
  logic [63:0] wr_d [16];

  function automatic logic [63:0] pat_word(logic [31:0] a, int beat, int k);
    return {a, 16'hC0DE, 8'(beat), 8'(k)};
  endfunction

  function automatic logic [255:0] pat_beat(logic [31:0] a, int beat);
    logic [255:0] r;
    for (int k = 0; k < 4; k++) r[k*64 +: 64] = pat_word(a, beat, k);
    return r;
  endfunction

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_req_vld = 1'b0;
      prev_rsp_rdy = 1'b0;
    end else begin
      cyc++;
      if (rf_we_o) begin
        if (wr_n < 16) begin
          wr_a[wr_n] = rf_waddr_o;
          wr_d[wr_n] = rf_wdata_o;
        end
        wr_n++;
        last_wr_cyc = cyc;
      end
      if (busy_o) busy_cyc++;
      if (done_o) begin done_cnt++; done_cyc = cyc; end
      if (err_o) err_cnt++;
      if (mem_req_ready_i && prev_req_vld) begin
        req_cnt++;
        got_addr = prev_addr;
        pend = 2; beat_i = 0; gapc = rsp_gap; waitc = 0;
        mem_req_ready_i = 1'b0;
      end else if (mem_req_valid_o && !mem_req_ready_i) begin
        if (waitc >= req_wait) mem_req_ready_i = 1'b1;
        else waitc++;
      end
      if (mem_rsp_valid_i && prev_rsp_rdy) begin
        beat_i++; pend--; gapc = rsp_gap;
        mem_rsp_valid_i = 1'b0;
      end
      if (pend > 0 && !mem_rsp_valid_i) begin
        if (gapc == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = pat_beat(got_addr, beat_i);
        end else gapc--;
      end
      prev_req_vld = mem_req_valid_o;
      prev_rsp_rdy = mem_rsp_ready_o;
      prev_addr    = mem_req_addr_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_n = 0; busy_cyc = 0; done_cnt = 0; err_cnt = 0; req_cnt = 0;
    last_wr_cyc = 0; done_cyc = 0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 ready in reset", 64'(req_ready_o), 1);
    chk({busy_o, done_o, err_o} == 3'b0, "R1 status in reset", 64'({busy_o, done_o, err_o}), 0);
    chk({rf_we_o, mem_req_valid_o, mem_rsp_ready_o} == 3'b0, "R1 bus idle in reset",
        64'({rf_we_o, mem_req_valid_o, mem_rsp_ready_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic check_writes(input int grp, input logic [31:0] base);
    int e = 0;
    for (int r = grp*8; r < grp*8 + 8; r++) begin
      if (r != 0) begin
        chk(wr_a[e] == 5'(r), "R4 write index", 64'(wr_a[e]), 64'(r));
        chk(wr_d[e] == pat_word(base, (r % 8) / 4, r % 4), "R4 write data",
            wr_d[e], pat_word(base, (r % 8) / 4, r % 4));
        e++;
      end
    end
  endtask

  task automatic t_load(input int grp, input logic [31:0] base, input int rw, input int rg,
                        input int exp_busy, input string tag);
    int nexp;
    req_wait = rw; rsp_gap = rg;
    clear_log();
    req_base_i = base; req_group_i = 2'(grp); req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(busy_o == 1'b1, {tag, " R7 busy after accept"}, 64'(busy_o), 1);
    for (int i = 0; i < 2000 && done_cnt == 0; i++) @(negedge clk_i);
    @(negedge clk_i);
    chk(done_cnt == 1, {tag, " R7 single done"}, 64'(done_cnt), 1);
    chk(done_cyc == last_wr_cyc + 1, {tag, " R7 done after last write"}, 64'(done_cyc), 64'(last_wr_cyc + 1));
    chk(busy_o == 1'b0, {tag, " R7 idle after done"}, 64'(busy_o), 0);
    chk(req_cnt == 1, {tag, " R2 one request"}, 64'(req_cnt), 1);
    chk(got_addr == base, {tag, " R2 R9 request address"}, 64'(got_addr), 64'(base));
    nexp = (grp == 0) ? 7 : 8;
    chk(wr_n == nexp, {tag, " R4 R5 write count"}, 64'(wr_n), 64'(nexp));
    if (wr_n == nexp) check_writes(grp, base);
    if (exp_busy >= 0)
      chk(busy_cyc == exp_busy, {tag, " R7 busy length"}, 64'(busy_cyc), 64'(exp_busy));
  endtask

  task automatic t_group0();
    t_load(0, 32'h0000_1000, 0, 0, 11, "g0");
    chk(wr_a[0] == 5'd1, "R5 first write is register 1", 64'(wr_a[0]), 1);
  endtask

  task automatic t_stall();
    // R6 R9: long request and response stalls
    t_load(3, 32'h0000_2040, 3, 5, -1, "stall");
  endtask

  task automatic t_misaligned();
    clear_log();
    req_base_i = 32'h0000_1010; req_group_i = 2'd1; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(err_o == 1'b1, "R3 error pulse", 64'(err_o), 1);
    chk(busy_o == 1'b0, "R3 not busy", 64'(busy_o), 0);
    @(negedge clk_i);
    chk(err_o == 1'b0, "R3 error one cycle", 64'(err_o), 0);
    repeat (6) @(negedge clk_i);
    chk(req_cnt == 0, "R3 no memory request", 64'(req_cnt), 0);
    chk(wr_n == 0, "R3 no writes", 64'(wr_n), 0);
    chk(busy_cyc == 0, "R3 no busy cycles", 64'(busy_cyc), 0);
  endtask

  task automatic t_busy_ignore();
    req_wait = 0; rsp_gap = 4;
    clear_log();
    req_base_i = 32'h0000_3000; req_group_i = 2'd2; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_base_i = 32'h0000_5000; req_group_i = 2'd1;
    chk(req_ready_o == 1'b0, "R8 not ready while busy", 64'(req_ready_o), 0);
    repeat (6) @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int i = 0; i < 2000 && done_cnt == 0; i++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(req_cnt == 1, "R8 only one request", 64'(req_cnt), 1);
    chk(got_addr == 32'h0000_3000, "R8 first request kept", 64'(got_addr), 64'h3000);
    chk(wr_n == 8, "R8 no extra writes", 64'(wr_n), 8);
    if (wr_n == 8) check_writes(2, 32'h0000_3000);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_load(1, 32'h0000_0800, 0, 0, 11, "g1");
    t_group0();
    t_stall();
    t_misaligned();
    t_busy_ignore();
    t_load(2, 32'hFFFF_FFC0, 1, 2, -1, "top");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule